// File: doc/BRIEF.md
# DDS Phase Generator with Table-Free Waveform Taps

This block is the phase engine of a direct digital synthesizer. An N-bit phase register, which stands for one full turn of 2π, advances by an unsigned frequency word each time the sample enable is high. It wraps modulo 2^N, so the output frequency is Fs·word/2^N. The word is one bit narrower than the register, which keeps the rate at or below Fs/2.

A downstream amplitude converter gets a P-bit phase: the top P bits of the register plus a modulation offset. It also gets a second phase a quarter turn ahead, for a cosine lookup. Three waveforms come straight from the register with no table:
- a square wave, which is the register MSB;
- a sawtooth, which is the raw register value;
- a triangle, which folds the sawtooth about its midpoint.

A change of frequency word alters only the step size. The register is never cleared by it, so the phase stays continuous.

Top module: `dds_phase_gen`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: the register is 0, so `saw_o`, `square_o` and `tri_o` read 0; `phase_o` reads 0; `quad_o` reads 2^(P-2).
- R2: On each clock edge with `sample_en` high, the register becomes (register + `tune_word`) modulo 2^N, and `saw_o` shows that new value.
- R3: On a clock edge with `sample_en` low, every output keeps its value, whatever `tune_word` and `phase_offset` are.
- R4: A change of `tune_word` never resets the register. The next enabled edge adds the new word to the current value.
- R5: `square_o` equals bit N-1 of `saw_o`.
- R6: Each bit i of `tri_o` (0 ≤ i ≤ N-2) equals `saw_o[i]` XOR `saw_o[N-1]`. The result rises from 0 to 2^(N-1)-1 and falls back over one turn.
- R7: After an enabled edge, `phase_o` equals (`saw_o[N-1:N-P]` + the `phase_offset` present at that edge) modulo 2^P. An offset change is therefore seen only after the next enabled edge.
- R8: `quad_o` always equals (`phase_o` + 2^(P-2)) modulo 2^P.
- R9: A `tune_word` of 0 holds the phase still. The maximum word 2^(N-1)-1 advances the register by that amount, wrapping past 2^N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| sample_en | input | 1 | Advances the register and loads the phase outputs |
| tune_word | input | N-1 | Phase step per sample (frequency word) |
| phase_offset | input | P | Phase modulation offset added to the truncated phase |
| phase_o | output | P | Truncated and offset phase for the amplitude converter |
| quad_o | output | P | Phase a quarter turn ahead of `phase_o` |
| square_o | output | 1 | Square wave, the register MSB |
| saw_o | output | N | Sawtooth, the raw register value |
| tri_o | output | N-1 | Triangle folded from the sawtooth |

## Verification
A wrong register value shows up on `saw_o` in the first cycle after the faulty enabled edge. Because the register only ever adds, the error then persists as a fixed phase offset on every later sample. A bad truncation or offset path shows as a mismatch between `phase_o` and the top bits of `saw_o` one enabled edge later. A broken quarter-turn adder shows as a gap other than 2^(P-2) between `quad_o` and `phase_o`. A fault in the hold path is exposed by edges with `sample_en` low: any output that moves on such an edge is wrong.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned DEF_ACC_W = 16;
  localparam int unsigned DEF_PH_W  = 10;
endpackage

// File: rtl/dds_accum.sv
module dds_accum #(
  parameter int unsigned ACC_W = dds_pkg::DEF_ACC_W,
  parameter int unsigned PH_W  = dds_pkg::DEF_PH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [ACC_W-2:0]   step,
  output logic [ACC_W-1:0]   acc_q,
  output logic [PH_W-1:0]    top_d
);
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = acc_q + {1'b0, step};
    top_d = acc_d[ACC_W-1 -: PH_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> acc_q == ACC_W'($past(acc_q) + {1'b0, $past(step)})); // R2
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q)); // R3
endmodule

// File: rtl/dds_phase_tap.sv
module dds_phase_tap #(
  parameter int unsigned PH_W = dds_pkg::DEF_PH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PH_W-1:0] top_d,
  input  logic [PH_W-1:0] offset,
  output logic [PH_W-1:0] phase_q,
  output logic [PH_W-1:0] quad_q
);
  localparam logic [PH_W-1:0] QTR = PH_W'(1) << (PH_W - 2);

  logic [PH_W-1:0] phase_d;
  logic [PH_W-1:0] quad_d;

  always_comb begin
    phase_d = top_d + offset;
    quad_d  = top_d + offset + QTR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      quad_q  <= QTR;
    end else if (en) begin
      phase_q <= phase_d;
      quad_q  <= quad_d;
    end
  end

  AST_QUAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    PH_W'(quad_q - phase_q) == QTR); // R8
endmodule

// File: rtl/dds_wave_tap.sv
module dds_wave_tap #(
  parameter int unsigned ACC_W = dds_pkg::DEF_ACC_W
) (
  input  logic [ACC_W-1:0] acc,
  output logic             square,
  output logic [ACC_W-1:0] saw,
  output logic [ACC_W-2:0] tri_w
);
  assign square = acc[ACC_W-1];
  assign saw    = acc;

  for (genvar i = 0; i < ACC_W - 1; i++) begin : g_fold
    assign tri_w[i] = acc[i] ^ acc[ACC_W-1];
  end
endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen #(
  parameter int unsigned ACC_W = dds_pkg::DEF_ACC_W,
  parameter int unsigned PH_W  = dds_pkg::DEF_PH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic [ACC_W-2:0] tune_word,
  input  logic [PH_W-1:0]  phase_offset,
  output logic [PH_W-1:0]  phase_o,
  output logic [PH_W-1:0]  quad_o,
  output logic             square_o,
  output logic [ACC_W-1:0] saw_o,
  output logic [ACC_W-2:0] tri_o
);
  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0]  top_d;

  dds_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .en(sample_en), .step(tune_word),
    .acc_q(acc), .top_d(top_d)
  );

  dds_phase_tap #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(sample_en), .top_d(top_d),
    .offset(phase_offset), .phase_q(phase_o), .quad_q(quad_o)
  );

  dds_wave_tap #(.ACC_W(ACC_W)) u_wave (
    .acc(acc), .square(square_o), .saw(saw_o), .tri_w(tri_o)
  );

  AST_PHASE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> phase_o == PH_W'(saw_o[ACC_W-1 -: PH_W] + $past(phase_offset))); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(phase_o) && $stable(quad_o)); // R3
endmodule

// File: tb/dds_phase_gen_tb.sv
module dds_phase_gen_tb;
  localparam int N = 16;
  localparam int P = 10;
  localparam logic [P-1:0] QTR = 10'd256;

  typedef struct packed {
    logic         en;
    logic [N-2:0] ftw;
    logic [P-1:0] off;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 15'd100,   10'd0},
    '{1'b1, 15'd100,   10'd0},
    '{1'b1, 15'd1000,  10'd5},
    '{1'b0, 15'd7777,  10'd9},
    '{1'b1, 15'd32767, 10'd0},
    '{1'b1, 15'd32767, 10'd1023},
    '{1'b1, 15'd0,     10'd3},
    '{1'b1, 15'd12345, 10'd512},
    '{1'b0, 15'd0,     10'd0},
    '{1'b1, 15'd20000, 10'd100},
    '{1'b1, 15'd1,     10'd1023},
    '{1'b1, 15'd16384, 10'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic sample_en;
  logic [N-2:0] tune_word;
  logic [P-1:0] phase_offset;
  logic [P-1:0] phase_o, quad_o;
  logic square_o;
  logic [N-1:0] saw_o;
  logic [N-2:0] tri_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [N-1:0] m_acc;
  logic [P-1:0] m_ph;

  always #10 clk = ~clk;

  dds_phase_gen #(.ACC_W(N), .PH_W(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .tune_word(tune_word),
    .phase_offset(phase_offset), .phase_o(phase_o), .quad_o(quad_o),
    .square_o(square_o), .saw_o(saw_o), .tri_o(tri_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [N-2:0] fold(input logic [N-1:0] a);
    logic [N-2:0] r;
    for (int i = 0; i < N - 1; i++) r[i] = a[i] ^ a[N-1];
    return r;
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " R2 saw"}, 32'(saw_o), 32'(m_acc));
    chk({tag, " R5 square"}, 32'(square_o), 32'(m_acc[N-1]));
    chk({tag, " R6 tri"}, 32'(tri_o), 32'(fold(m_acc)));
    chk({tag, " R7 phase"}, 32'(phase_o), 32'(m_ph));
    chk({tag, " R8 quad"}, 32'(quad_o), 32'(P'(m_ph + QTR)));
  endtask

  task automatic step(input logic en, input logic [N-2:0] ftw, input logic [P-1:0] off);
    @(negedge clk);
    sample_en = en; tune_word = ftw; phase_offset = off;
    @(posedge clk);
    if (en) begin
      m_acc = m_acc + {1'b0, ftw};
      m_ph  = P'(m_acc[N-1 -: P] + off);
    end
    #5;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sample_en = 1'b0; tune_word = '0; phase_offset = '0;
    m_acc = '0; m_ph = '0;
    repeat (3) @(posedge clk);
    #5;
    check_all("reset R1");
    @(negedge clk) rst_n = 1'b1;

    // Vector table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < 12; k++) begin
      step(VECS[k].en, VECS[k].ftw, VECS[k].off);
      check_all($sformatf("vec%0d", k));
    end

    // R3: offset and word change while disabled leave outputs untouched
    step(1'b0, 15'd999, 10'd77);
    check_all("hold R3");

    // R7: offset reaches phase only after an enabled edge (zero step)
    step(1'b1, 15'd0, 10'd77);
    check_all("offset R7");

    // R9: zero word holds phase over several samples
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 15'd0, 10'd77);
      chk("R9 zero word", 32'(saw_o), 32'(m_acc));
    end

    // R4: new word continues from current phase, R9 max word wraps
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 15'h7FFF, 10'd0);
      check_all("maxword R9 R4");
    end
    step(1'b1, 15'd3, 10'd0);
    check_all("newword R4");

    // R6: triangle at the fold point
    while (m_acc[N-1] == 1'b0) begin
      step(1'b1, 15'd4096, 10'd0);
    end
    check_all("fold R6");

    // R1: asynchronous reset mid-run
    @(negedge clk);
    sample_en = 1'b1; tune_word = 15'd500; phase_offset = 10'd3;
    #3 rst_n = 1'b0;
    m_acc = '0; m_ph = '0;
    #2;
    check_all("midreset R1");
    @(posedge clk); #5;
    check_all("heldreset R1");
    @(negedge clk) rst_n = 1'b1; sample_en = 1'b0;
    step(1'b1, 15'd500, 10'd3);
    check_all("afterreset R2");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule